// File: doc/BRIEF.md
# PLL Parameter Selection Controller

This block chooses the P, M and S control values for several PLLs in a clock subsystem. Each PLL has two possible sources. One is a set of strap pins. The other is a software parameter register. After reset every PLL takes its values from the straps. Software switches a PLL to its register by setting that PLL's source bit in a shared configuration register.

A per-PLL clock-enable bit in the same configuration register protects the output clock. While the bit is 1, the clock runs and the values driven to the PLL stay frozen, even if software writes the parameter register. While the bit is 0, the clock is gated and the values driven to the PLL track the parameter register. Software reprograms a PLL by clearing its enable bit, writing the new values, then setting the bit again. The PLL therefore never sees a change while its clock is live.

For each PLL the block also reports the frequency ratio of the selected values as a numerator M+8 and a denominator (P+2)·2^S. A small decoder turns the CPU and system-bus clock-select codes into nominal frequencies in MHz.

Each channel holds one of four named states, in encoding order:
- `CH_PIN_RUN`: straps selected, clock running.
- `CH_PIN_GATED`: straps selected, clock gated.
- `CH_REG_RUN`: register selected, clock running.
- `CH_REG_GATED`: register selected, clock gated.

Every configuration write moves a channel to the state given by its new source bit and enable bit. Any state can reach any other, and the channel stays in its state when there is no configuration write. Reset enters `CH_PIN_RUN`.

The parameter `NPLL` sets the number of PLLs and may range from 1 to 4.

Top module: `pll_param_ctrl`

## Requirements
- R1: After reset every PLL is in `CH_PIN_RUN`. `pll_clk_en` is all ones, every parameter register reads 0, and the configuration register reads only its enable bits set (0x0F000000 for four PLLs).
- R2: The configuration register is at address 0. PLL i has its source bit at bit 28+i (1 selects the register) and its clock-enable bit at bit 24+i. A write takes effect at the clock edge that accepts it, and `pll_clk_en[i]` then equals the enable bit.
- R3: While PLL i selects the straps, its M, P and S outputs equal its strap inputs, following strap changes combinationally.
- R4: The parameter register of PLL i is at address 1+i. Its fields are M in bits [7:0], P in bits [13:8] and S in bits [15:14]. A write while PLL i is in `CH_REG_GATED` appears on its outputs in the cycle after the write is accepted.
- R5: A parameter write while PLL i's clock-enable bit is 1 does not change the values driven to that PLL.
- R6: One cycle after a PLL enters a gated state, the values driven to it equal its stored parameter register, so a write made earlier is applied then.
- R7: A parameter register read returns bits [15:0] of the last value written, with bits [31:16] reading 0.
- R8: Configuration bits outside the source and enable fields read 0 and ignore writes.
- R9: For each PLL, `ratio_num` is M+8 and `ratio_den` is (P+2) shifted left by S, computed from the selected values. This covers the extremes 263/520 (all fields at maximum) and 8/2 (all fields zero).
- R10: CPU select codes 0 to 7 decode to 133, 133, 133, 125, 100, 66, 50 and 33 MHz. A system-bus select code of 3'b110 decodes to 50 MHz, and every other code decodes to 0.
- R11: Addresses above NPLL read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| strap_m | input | NPLL*8 | Strap M value per PLL |
| strap_p | input | NPLL*6 | Strap P value per PLL |
| strap_s | input | NPLL*2 | Strap S value per PLL |
| cpu_sel | input | 3 | CPU clock-select code |
| sysbus_sel | input | 3 | System-bus clock-select code |
| pll_m | output | NPLL*8 | M value driven to each PLL |
| pll_p | output | NPLL*6 | P value driven to each PLL |
| pll_s | output | NPLL*2 | S value driven to each PLL |
| pll_clk_en | output | NPLL | Clock-gate enable per PLL |
| ratio_num | output | NPLL*9 | Ratio numerator M+8 per PLL |
| ratio_den | output | NPLL*10 | Ratio denominator (P+2)<<S per PLL |
| cpu_mhz | output | 8 | Decoded CPU clock in MHz |
| sysbus_mhz | output | 8 | Decoded system-bus clock in MHz |

## Verification
These results are due with no delay after a stimulus:
- Strap-driven outputs, the ratios, the frequency decode and read data follow their inputs combinationally. The bench checks them 1 ns after changing those inputs.

These results are due after clock edges:
- A configuration write updates the channel state and `pll_clk_en` at the edge that accepts the write.
- A parameter write in the gated register state reaches the outputs at that same edge.
- A value written earlier is applied one edge after the gated state begins.

Each write task ends at the falling edge after its accepting rising edge. Every expectation is queued at a falling-edge point that has been counted forward from the stimulus in this way.

// File: rtl/pllsel_pkg.sv
package pllsel_pkg;
    localparam int M_W      = 8;
    localparam int P_W      = 6;
    localparam int S_W      = 2;
    localparam int PAR_W    = M_W + P_W + S_W;
    localparam int M_LSB    = 0;
    localparam int P_LSB    = M_W;
    localparam int S_LSB    = M_W + P_W;
    localparam int DATA_W   = 32;
    localparam int SRC_LSB  = 28;
    localparam int EN_LSB   = 24;
    localparam int M_BIAS   = 8;
    localparam int P_BIAS   = 2;
    localparam int NUM_W    = M_W + 1;
    localparam int DEN_W    = P_W + 1 + (1 << S_W) - 1;
    localparam int SEL_W    = 3;
    localparam int MHZ_W    = 8;

    typedef enum logic [1:0] {
        CH_PIN_RUN   = 2'b00,
        CH_PIN_GATED = 2'b01,
        CH_REG_RUN   = 2'b10,
        CH_REG_GATED = 2'b11
    } ch_state_e;
endpackage

// File: rtl/pllsel_bus.sv
module pllsel_bus
    import pllsel_pkg::*;
#(
    parameter int NPLL   = 4,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic [NPLL-1:0]         src_q,
    input  logic [NPLL-1:0]         en_q,
    input  logic [NPLL*PAR_W-1:0]   shadow_q,
    output logic                    cfg_wr,
    output logic [NPLL-1:0]         cfg_src,
    output logic [NPLL-1:0]         cfg_en,
    output logic [NPLL-1:0]         par_wr,
    output logic [PAR_W-1:0]        par_wdata,
    output logic [DATA_W-1:0]       bus_rdata
);
    function automatic logic [DATA_W-1:0] live_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NPLL; i++) begin
            m[SRC_LSB+i] = 1'b1;
            m[EN_LSB+i]  = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] LIVE_MASK = live_bits();

    assign cfg_wr    = bus_wr && (bus_addr == '0);
    assign cfg_src   = bus_wdata[SRC_LSB +: NPLL];
    assign cfg_en    = bus_wdata[EN_LSB +: NPLL];
    assign par_wdata = bus_wdata[PAR_W-1:0];

    for (genvar g = 0; g < NPLL; g++) begin : g_wr
        assign par_wr[g] = bus_wr && (bus_addr == ADDR_W'(g + 1));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) begin
            for (int i = 0; i < NPLL; i++) begin
                bus_rdata[SRC_LSB+i] = src_q[i];
                bus_rdata[EN_LSB+i]  = en_q[i];
            end
        end
        for (int i = 0; i < NPLL; i++) begin
            if (bus_addr == ADDR_W'(i + 1)) begin
                bus_rdata[PAR_W-1:0] = shadow_q[i*PAR_W +: PAR_W];
            end
        end
    end

    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> ((bus_rdata & ~LIVE_MASK) == '0));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) > NPLL) |-> (bus_rdata == '0));
endmodule

// File: rtl/pllsel_channel.sv
module pllsel_channel
    import pllsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_src,
    input  logic             cfg_en,
    input  logic             par_wr,
    input  logic [PAR_W-1:0] par_wdata,
    input  logic [M_W-1:0]   strap_m,
    input  logic [P_W-1:0]   strap_p,
    input  logic [S_W-1:0]   strap_s,
    output logic [M_W-1:0]   out_m,
    output logic [P_W-1:0]   out_p,
    output logic [S_W-1:0]   out_s,
    output logic             clk_en,
    output logic             src_reg,
    output logic [PAR_W-1:0] shadow,
    output logic [NUM_W-1:0] ratio_num,
    output logic [DEN_W-1:0] ratio_den
);
    ch_state_e        state, state_nx;
    logic [PAR_W-1:0] applied;
    logic             gated;
    logic [DEN_W-1:0] den_base;

    always_comb begin
        state_nx = state;
        if (cfg_wr) begin
            unique case ({cfg_src, cfg_en})
                2'b00: state_nx = CH_PIN_GATED;
                2'b01: state_nx = CH_PIN_RUN;
                2'b10: state_nx = CH_REG_GATED;
                2'b11: state_nx = CH_REG_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_PIN_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            CH_PIN_RUN:   begin src_reg = 1'b0; clk_en = 1'b1; gated = 1'b0; end
            CH_PIN_GATED: begin src_reg = 1'b0; clk_en = 1'b0; gated = 1'b1; end
            CH_REG_RUN:   begin src_reg = 1'b1; clk_en = 1'b1; gated = 1'b0; end
            CH_REG_GATED: begin src_reg = 1'b1; clk_en = 1'b0; gated = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shadow <= '0;
        else if (par_wr) shadow <= par_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     applied <= '0;
        else if (gated) applied <= par_wr ? par_wdata : shadow;
    end

    always_comb begin
        if (src_reg) begin
            out_m = applied[M_LSB +: M_W];
            out_p = applied[P_LSB +: P_W];
            out_s = applied[S_LSB +: S_W];
        end else begin
            out_m = strap_m;
            out_p = strap_p;
            out_s = strap_s;
        end
    end

    assign ratio_num = NUM_W'(out_m) + NUM_W'(M_BIAS);
    assign den_base  = DEN_W'(out_p) + DEN_W'(P_BIAS);
    assign ratio_den = den_base << out_s;

    a_r2_en_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (clk_en == $past(cfg_en)) && (src_reg == $past(cfg_src)));

    a_r4_gated_load: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr && gated) |=> (applied == $past(par_wdata)));

    a_r5_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CH_REG_RUN) && ($past(state) == CH_REG_RUN))
            |-> ($stable(out_m) && $stable(out_p) && $stable(out_s)));

    a_r9_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_num >= NUM_W'(M_BIAS)) && (ratio_den >= DEN_W'(P_BIAS)));
endmodule

// File: rtl/pllsel_freq_decode.sv
module pllsel_freq_decode
    import pllsel_pkg::*;
(
    input  logic [SEL_W-1:0] cpu_sel,
    input  logic [SEL_W-1:0] sysbus_sel,
    output logic [MHZ_W-1:0] cpu_mhz,
    output logic [MHZ_W-1:0] sysbus_mhz
);
    always_comb begin
        unique case (cpu_sel)
            3'd0, 3'd1, 3'd2: cpu_mhz = MHZ_W'(133);
            3'd3:             cpu_mhz = MHZ_W'(125);
            3'd4:             cpu_mhz = MHZ_W'(100);
            3'd5:             cpu_mhz = MHZ_W'(66);
            3'd6:             cpu_mhz = MHZ_W'(50);
            3'd7:             cpu_mhz = MHZ_W'(33);
        endcase
    end

    assign sysbus_mhz = (sysbus_sel == 3'b110) ? MHZ_W'(50) : '0;
endmodule

// File: rtl/pll_param_ctrl.sv
module pll_param_ctrl
    import pllsel_pkg::*;
#(
    parameter int NPLL   = 4,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPLL*8-1:0]     strap_m,
    input  logic [NPLL*6-1:0]     strap_p,
    input  logic [NPLL*2-1:0]     strap_s,
    input  logic [2:0]            cpu_sel,
    input  logic [2:0]            sysbus_sel,
    output logic [NPLL*8-1:0]     pll_m,
    output logic [NPLL*6-1:0]     pll_p,
    output logic [NPLL*2-1:0]     pll_s,
    output logic [NPLL-1:0]       pll_clk_en,
    output logic [NPLL*9-1:0]     ratio_num,
    output logic [NPLL*10-1:0]    ratio_den,
    output logic [7:0]            cpu_mhz,
    output logic [7:0]            sysbus_mhz
);
    logic                    cfg_wr;
    logic [NPLL-1:0]         cfg_src, cfg_en, par_wr, src_q;
    logic [PAR_W-1:0]        par_wdata;
    logic [NPLL*PAR_W-1:0]   shadow_q;

    pllsel_bus #(.NPLL(NPLL), .ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .src_q     (src_q),
        .en_q      (pll_clk_en),
        .shadow_q  (shadow_q),
        .cfg_wr    (cfg_wr),
        .cfg_src   (cfg_src),
        .cfg_en    (cfg_en),
        .par_wr    (par_wr),
        .par_wdata (par_wdata),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NPLL; g++) begin : g_ch
        pllsel_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_wr),
            .cfg_src   (cfg_src[g]),
            .cfg_en    (cfg_en[g]),
            .par_wr    (par_wr[g]),
            .par_wdata (par_wdata),
            .strap_m   (strap_m[g*M_W +: M_W]),
            .strap_p   (strap_p[g*P_W +: P_W]),
            .strap_s   (strap_s[g*S_W +: S_W]),
            .out_m     (pll_m[g*M_W +: M_W]),
            .out_p     (pll_p[g*P_W +: P_W]),
            .out_s     (pll_s[g*S_W +: S_W]),
            .clk_en    (pll_clk_en[g]),
            .src_reg   (src_q[g]),
            .shadow    (shadow_q[g*PAR_W +: PAR_W]),
            .ratio_num (ratio_num[g*NUM_W +: NUM_W]),
            .ratio_den (ratio_den[g*DEN_W +: DEN_W])
        );
    end

    pllsel_freq_decode u_freq (
        .cpu_sel    (cpu_sel),
        .sysbus_sel (sysbus_sel),
        .cpu_mhz    (cpu_mhz),
        .sysbus_mhz (sysbus_mhz)
    );
endmodule

// File: tb/pll_param_ctrl_tb_top.sv
module pll_param_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPLL = 4;
    localparam int AW = 4;

    localparam int K_RD = 0, K_EN = 1, K_M = 2, K_P = 3, K_S = 4,
                   K_NUM = 5, K_DEN = 6, K_CPU = 7, K_SYS = 8;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NPLL*8-1:0] strap_m = '0, pll_m;
    logic [NPLL*6-1:0] strap_p = '0, pll_p;
    logic [NPLL*2-1:0] strap_s = '0, pll_s;
    logic [2:0] cpu_sel = '0, sysbus_sel = '0;
    logic [NPLL-1:0] pll_clk_en;
    logic [NPLL*9-1:0] ratio_num;
    logic [NPLL*10-1:0] ratio_den;
    logic [7:0] cpu_mhz, sysbus_mhz;

    pll_param_ctrl #(.NPLL(NPLL), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .strap_m(strap_m), .strap_p(strap_p), .strap_s(strap_s),
        .cpu_sel(cpu_sel), .sysbus_sel(sysbus_sel),
        .pll_m(pll_m), .pll_p(pll_p), .pll_s(pll_s), .pll_clk_en(pll_clk_en),
        .ratio_num(ratio_num), .ratio_den(ratio_den),
        .cpu_mhz(cpu_mhz), .sysbus_mhz(sysbus_mhz)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] expv;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  sb_ev;
    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    function automatic logic [31:0] observe(int kind, int idx);
        case (kind)
            K_RD:  return bus_rdata;
            K_EN:  return 32'(pll_clk_en);
            K_M:   return 32'(pll_m[idx*8 +: 8]);
            K_P:   return 32'(pll_p[idx*6 +: 6]);
            K_S:   return 32'(pll_s[idx*2 +: 2]);
            K_NUM: return 32'(ratio_num[idx*9 +: 9]);
            K_DEN: return 32'(ratio_den[idx*10 +: 10]);
            K_CPU: return 32'(cpu_mhz);
            default: return 32'(sysbus_mhz);
        endcase
    endfunction

    // Monitor: pops expectations and compares against the ports.
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = observe(it.kind, it.idx);
                n_checks++;
                if (act !== it.expv) begin
                    n_err++;
                    $display("FAIL %s: kind %0d idx %0d actual=%0h expected=%0h",
                             it.tag, it.kind, it.idx, act, it.expv);
                end
            end
        end
    end

    task automatic expect_val(int kind, int idx, logic [31:0] expv, string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.expv = expv; it.tag = tag;
        sb_q.push_back(it);
        -> sb_ev;
        #1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd_chk(logic [AW-1:0] a, logic [31:0] e, string tag);
        bus_addr = a;
        #1;
        expect_val(K_RD, 0, e, tag);
    endtask

    task automatic chk_pll(int i, int m, int p, int s, string tag);
        expect_val(K_M, i, 32'(m), tag);
        expect_val(K_P, i, 32'(p), tag);
        expect_val(K_S, i, 32'(s), tag);
        expect_val(K_NUM, i, 32'(m + 8), {tag, " R9"});
        expect_val(K_DEN, i, 32'((p + 2) << s), {tag, " R9"});
    endtask

    task automatic set_strap(int i, int m, int p, int s);
        strap_m[i*8 +: 8] = 8'(m);
        strap_p[i*6 +: 6] = 6'(p);
        strap_s[i*2 +: 2] = 2'(s);
        #1;
    endtask

    function automatic int cpu_ref(int c);
        case (c)
            0, 1, 2: return 133;
            3: return 125;
            4: return 100;
            5: return 66;
            6: return 50;
            default: return 33;
        endcase
    endfunction

    initial begin
        for (int i = 0; i < NPLL; i++) set_strap(i, 16 + i, 3 + i, i % 4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        expect_val(K_EN, 0, 32'hF, "R1 clk_en");
        rd_chk(0, 32'h0F00_0000, "R1 cfg");
        for (int i = 1; i <= NPLL; i++) rd_chk(AW'(i), 0, "R1 par");
        // R3 pin mode follows straps
        for (int i = 0; i < NPLL; i++) chk_pll(i, 16 + i, 3 + i, i % 4, "R3 strap");
        set_strap(2, 8'h5A, 6'h11, 1);
        chk_pll(2, 8'h5A, 6'h11, 1, "R3 strap change");
        // R5 write while running; R7 readback
        wr(2, 32'hFFFF_ABCD);
        rd_chk(2, 32'h0000_ABCD, "R7 readback");
        wr(0, 32'h2F00_0000);
        expect_val(K_EN, 0, 32'hF, "R2 en");
        chk_pll(1, 0, 0, 0, "R5 held");
        // R2 gate PLL1; R6 pending value applied
        wr(0, 32'h2D00_0000);
        expect_val(K_EN, 0, 32'hD, "R2 gate");
        @(negedge clk); #1;
        chk_pll(1, 8'hCD, 6'h2B, 2, "R6 apply");
        // R4 write while gated
        wr(2, 32'h0000_1234);
        chk_pll(1, 8'h34, 6'h12, 0, "R4 gated write");
        // R5 ungate then write
        wr(0, 32'h2F00_0000);
        wr(2, 32'h0000_5678);
        @(negedge clk); @(negedge clk); #1;
        chk_pll(1, 8'h34, 6'h12, 0, "R5 run write");
        rd_chk(2, 32'h0000_5678, "R7 readback2");
        // R8 reserved bits
        wr(0, 32'hFFFF_FFFF);
        rd_chk(0, 32'hFF00_0000, "R8 rsvd");
        chk_pll(0, 0, 0, 0, "R2 src reg");
        wr(0, 32'h0000_0000);
        expect_val(K_EN, 0, 32'h0, "R2 all gated");
        rd_chk(0, 32'h0, "R8 cfg zero");
        chk_pll(1, 17, 4, 1, "R3 back to pins");
        // R11 unmapped
        wr(7, 32'hFFFF_FFFF);
        rd_chk(7, 0, "R11 unmapped");
        rd_chk(5, 0, "R11 unmapped5");
        rd_chk(0, 0, "R11 cfg kept");
        rd_chk(2, 32'h0000_5678, "R11 par kept");
        // R9 extremes
        set_strap(3, 8'hFF, 6'h3F, 3);
        expect_val(K_NUM, 3, 263, "R9 max num");
        expect_val(K_DEN, 3, 520, "R9 max den");
        set_strap(3, 0, 0, 0);
        expect_val(K_NUM, 3, 8, "R9 min num");
        expect_val(K_DEN, 3, 2, "R9 min den");
        // R10 decode
        for (int c = 0; c < 8; c++) begin
            cpu_sel = 3'(c);
            sysbus_sel = 3'(c);
            #1;
            expect_val(K_CPU, 0, 32'(cpu_ref(c)), "R10 cpu");
            expect_val(K_SYS, 0, (c == 6) ? 32'd50 : 32'd0, "R10 sysbus");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule